// File: doc/BRIEF.md
# Serial Clock Rate Best-Match Search

This block picks the divider settings for a serial clock. It takes the system clock frequency and a requested serial clock frequency, both as plain integers in hertz. From a fixed set of prescale and scale divisors, it finds the pair whose resulting rate lies closest to the request. It also decides whether the doubled-rate mode must be on. A request that the divider chain cannot reach is refused.

A one-cycle `start` begins a search. `busy` stays high for the whole search. When the search ends, `done` pulses for one cycle, and in that same cycle the result outputs already hold the new values. Each candidate is computed with a shared iterative divider. The system clock is divided by one prescale divisor. That base is then divided by each of the sixteen scale divisors in turn. Because of this, every accepted search takes the same number of cycles.

Top module: `baudSearch`

## Requirements
- R1: A `start` sampled high while `busy` is low makes `busy` high from the next cycle. At the end of a search, `done` is high for exactly one cycle and `busy` is low in that cycle.
- R2: A `start` pulse sampled while `busy` is high is ignored. The running search keeps its latency, gives a single `done`, and `busy` is low in the cycle after that `done`.
- R3: A request is refused when it exceeds floor(sys/2), or when it is below floor(sys/229376). On refusal, `rangeErr` is 1 at `done`, and `preCode`, `sclCode` and `dblRate` keep their previous values. A request equal to either bound is accepted, and then `rangeErr` is 0.
- R4: For an accepted request, `dblRate` is 1 when the request exceeds floor(sys/4) or `dblIn` is 1. Otherwise it is 0.
- R5: The prescale code is 0 to 3 and selects the divisor 2, 3, 5 or 7. The scale code is 0 to 15 and selects 2, 4, 6, 8, and then 2 to the power of the code for codes 4 to 15. The candidate rate is floor(floor(sys/pre)/scl), doubled when `dblRate` is 1.
- R6: The reported pair minimises the absolute difference between candidate and request. Pairs are tried with the prescale code as the outer loop and the scale code as the inner loop, both ascending. A later pair replaces the best only when its difference is strictly smaller, so ties keep the earlier pair.
- R7: `done` rises exactly 2 + 68·(W+2) clock edges after the edge that samples `start` for an accepted request, which is 2314 at W = 32. For a refused request it rises after 1 edge.
- R8: `preCode`, `sclCode` and `dblRate` do not change while `busy` is high.
- R9: After reset, `busy`, `done`, `rangeErr`, `dblRate`, `preCode` and `sclCode` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a search when idle |
| sysClk | input | W | System clock frequency in Hz |
| reqRate | input | W | Requested serial clock frequency in Hz |
| dblIn | input | 1 | Doubled-rate mode is already on |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| preCode | output | 2 | Chosen prescale code |
| sclCode | output | 4 | Chosen scale code |
| dblRate | output | 1 | Doubled-rate decision |
| rangeErr | output | 1 | Request was out of reach |

## Verification
The assertions assume that `sysClk`, `reqRate` and `dblIn` are held steady from the `start` edge until `done`. They also assume `sysClk` stays below 2^(W-1), so that a doubled candidate and the initial best difference cannot overflow. The bench sets these three inputs before it raises `start` and does not touch them until `done` has been seen. When it pokes `start` during a search, it changes nothing else. Random system clocks are drawn between 2 MHz and 500 MHz. Requests are drawn as that clock shifted right by 1 to 19 places plus jitter, so they land both inside and just outside the reachable range.

// File: rtl/baudPkg.sv
package baudPkg;
  localparam int PRE_N = 4;
  localparam int SCL_N = 16;
  localparam int PRE_W = $clog2(PRE_N);
  localparam int SCL_W = $clog2(SCL_N);
  // slowest reachable rate divides the clock by the largest prescale times the largest scale
  localparam longint LOW_DIV = 64'd7 * 64'd32768;

  typedef struct packed {
    logic capture;   // latch inputs, reset the best-so-far
    logic divGo;     // launch one division
    logic divStage;  // 0: sys / prescale, 1: base / scale
    logic keepBase;  // store the prescaled base
    logic evalCand;  // compare the candidate against the best
    logic commit;    // publish the best pair
    logic reject;    // publish a range refusal
    logic [PRE_W-1:0] preIdx;
    logic [SCL_W-1:0] sclIdx;
  } ctrlStrb_t;

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_PRE_GO, S_PRE_WAIT, S_SCL_GO, S_SCL_WAIT, S_FIN
  } state_t;

  function automatic logic [2:0] preDiv(input logic [PRE_W-1:0] code);
    case (code)
      2'd0:    return 3'd2;
      2'd1:    return 3'd3;
      2'd2:    return 3'd5;
      default: return 3'd7;
    endcase
  endfunction

  function automatic logic [15:0] sclDiv(input logic [SCL_W-1:0] code);
    if (code < 4'd4) return 16'(2 * (int'(code) + 1));
    return 16'(1) << code;
  endfunction
endpackage

// File: rtl/baudDiv.sv
module baudDiv #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quot,
  output logic         rdy
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  remR;
  logic [W-1:0]  dvsR;
  logic [CW-1:0] cnt;
  logic          run;
  logic [W:0]    trial;
  logic [W:0]    trialSub;
  logic          fits;

  always_comb begin
    trial    = {remR, quot[W-1]};
    trialSub = trial - {1'b0, dvsR};
    fits     = trial >= {1'b0, dvsR};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remR <= '0;
      dvsR <= '0;
      quot <= '0;
      cnt  <= '0;
      run  <= 1'b0;
      rdy  <= 1'b0;
    end else begin
      rdy <= 1'b0;
      if (go) begin
        remR <= '0;
        quot <= dividend;
        dvsR <= divisor;
        cnt  <= CW'(W);
        run  <= 1'b1;
      end else if (run) begin
        remR <= fits ? trialSub[W-1:0] : trial[W-1:0];
        quot <= {quot[W-2:0], fits};
        cnt  <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          run <= 1'b0;
          rdy <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/baudSearchPath.sv
module baudSearchPath
  import baudPkg::*;
#(
  parameter int W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrb_t        strb,
  input  logic [W-1:0]     sysClk,
  input  logic [W-1:0]     reqRate,
  input  logic             dblIn,
  output logic             rangeBad,
  output logic             divRdy,
  output logic [PRE_W-1:0] preCode,
  output logic [SCL_W-1:0] sclCode,
  output logic             dblRate,
  output logic             rangeErr
);
  localparam logic [W-1:0] ERR_INIT = {1'b0, {(W-1){1'b1}}};

  logic [W-1:0]     sysR, reqR, baseR, bestErr;
  logic             dblW;
  logic [PRE_W-1:0] bestPre;
  logic [SCL_W-1:0] bestScl;
  logic [W-1:0]     divA, divB, quot, cand, diff;
  logic [2*W-1:0]   loProd;

  always_comb begin
    divA     = strb.divStage ? baseR : sysR;
    divB     = strb.divStage ? W'(sclDiv(strb.sclIdx)) : W'(preDiv(strb.preIdx));
    loProd   = ((2*W)'(reqR) + (2*W)'(1)) * (2*W)'(LOW_DIV);
    rangeBad = (reqR > (sysR >> 1)) || (loProd <= (2*W)'(sysR));
    cand     = dblW ? {quot[W-2:0], 1'b0} : quot;
    diff     = (cand > reqR) ? (cand - reqR) : (reqR - cand);
  end

  baudDiv #(.W(W)) uDiv (
    .clk(clk), .rstN(rstN), .go(strb.divGo),
    .dividend(divA), .divisor(divB), .quot(quot), .rdy(divRdy)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sysR     <= '0;
      reqR     <= '0;
      baseR    <= '0;
      dblW     <= 1'b0;
      bestErr  <= ERR_INIT;
      bestPre  <= '0;
      bestScl  <= '0;
      preCode  <= '0;
      sclCode  <= '0;
      dblRate  <= 1'b0;
      rangeErr <= 1'b0;
    end else begin
      if (strb.capture) begin
        sysR    <= sysClk;
        reqR    <= reqRate;
        dblW    <= dblIn | (reqRate > (sysClk >> 2));
        bestErr <= ERR_INIT;
        bestPre <= '0;
        bestScl <= '0;
      end
      if (strb.keepBase) baseR <= quot;
      if (strb.evalCand && (diff < bestErr)) begin
        bestErr <= diff;
        bestPre <= strb.preIdx;
        bestScl <= strb.sclIdx;
      end
      if (strb.commit) begin
        preCode  <= bestPre;
        sclCode  <= bestScl;
        dblRate  <= dblW;
        rangeErr <= 1'b0;
      end
      if (strb.reject) rangeErr <= 1'b1;
    end
  end
endmodule

// File: rtl/baudSearchCtrl.sv
module baudSearchCtrl
  import baudPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      rangeBad,
  input  logic      divRdy,
  output ctrlStrb_t strb,
  output logic      busy,
  output logic      done
);
  state_t           state, nextState;
  logic [PRE_W-1:0] preIdx;
  logic [SCL_W-1:0] sclIdx;
  logic             lastScl, lastPre;

  always_comb begin
    lastScl   = sclIdx == SCL_W'(SCL_N - 1);
    lastPre   = preIdx == PRE_W'(PRE_N - 1);
    strb      = '0;
    strb.preIdx = preIdx;
    strb.sclIdx = sclIdx;
    nextState = state;
    case (state)
      S_IDLE: if (start) begin
        strb.capture = 1'b1;
        nextState    = S_CHECK;
      end
      S_CHECK: begin
        if (rangeBad) begin
          strb.reject = 1'b1;
          nextState   = S_IDLE;
        end else begin
          nextState = S_PRE_GO;
        end
      end
      S_PRE_GO: begin
        strb.divGo = 1'b1;
        nextState  = S_PRE_WAIT;
      end
      S_PRE_WAIT: if (divRdy) begin
        strb.keepBase = 1'b1;
        nextState     = S_SCL_GO;
      end
      S_SCL_GO: begin
        strb.divGo    = 1'b1;
        strb.divStage = 1'b1;
        nextState     = S_SCL_WAIT;
      end
      S_SCL_WAIT: begin
        strb.divStage = 1'b1;
        if (divRdy) begin
          strb.evalCand = 1'b1;
          if (!lastScl)     nextState = S_SCL_GO;
          else if (lastPre) nextState = S_FIN;
          else              nextState = S_PRE_GO;
        end
      end
      S_FIN: begin
        strb.commit = 1'b1;
        nextState   = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      preIdx <= '0;
      sclIdx <= '0;
      done   <= 1'b0;
    end else begin
      state <= nextState;
      done  <= strb.commit | strb.reject;
      if (strb.capture) begin
        preIdx <= '0;
        sclIdx <= '0;
      end else if (strb.evalCand) begin
        sclIdx <= sclIdx + 1'b1;
        if (lastScl) preIdx <= preIdx + 1'b1;
      end
    end
  end

  assign busy = state != S_IDLE;
endmodule

// File: rtl/baudSearch.sv
module baudSearch
  import baudPkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [W-1:0] sysClk,
  input  logic [W-1:0] reqRate,
  input  logic         dblIn,
  output logic         busy,
  output logic         done,
  output logic [1:0]   preCode,
  output logic [3:0]   sclCode,
  output logic         dblRate,
  output logic         rangeErr
);
  ctrlStrb_t strb;
  logic      rangeBad, divRdy;

  baudSearchCtrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .rangeBad(rangeBad),
    .divRdy(divRdy), .strb(strb), .busy(busy), .done(done)
  );

  baudSearchPath #(.W(W)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .sysClk(sysClk), .reqRate(reqRate),
    .dblIn(dblIn), .rangeBad(rangeBad), .divRdy(divRdy), .preCode(preCode),
    .sclCode(sclCode), .dblRate(dblRate), .rangeErr(rangeErr)
  );
endmodule

// File: rtl/baudSearchChk.sv
module baudSearchChk (
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic       dblIn,
  input logic       busy,
  input logic       done,
  input logic [1:0] preCode,
  input logic [3:0] sclCode,
  input logic       dblRate,
  input logic       rangeErr
);
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    start && !busy |=> busy); // R1
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R1
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R1
  AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    done && rangeErr |-> $stable(preCode) && $stable(sclCode) && $stable(dblRate)); // R3
  AST_DBL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    done && !rangeErr && dblIn |-> dblRate); // R4
  AST_OUT_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> $stable(preCode) && $stable(sclCode) && $stable(dblRate)); // R8
endmodule

bind baudSearch baudSearchChk uChk (
  .clk(clk), .rstN(rstN), .start(start), .dblIn(dblIn), .busy(busy),
  .done(done), .preCode(preCode), .sclCode(sclCode), .dblRate(dblRate),
  .rangeErr(rangeErr)
);

// File: tb/baudSearch_test.sv
`timescale 1ns/1ps
module baudSearch_test;
  localparam int W = 32;
  localparam int LAT_OK = 2 + 68 * (W + 2);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] sysClk = '0, reqRate = '0;
  logic dblIn = 1'b0;
  logic busy, done, dblRate, rangeErr;
  logic [1:0] preCode;
  logic [3:0] sclCode;

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  int mPre = 0, mScl = 0;
  bit mDbl = 1'b0;

  always #2 clk = ~clk;

  baudSearch #(.W(W)) uut (
    .clk(clk), .rstN(rstN), .start(start), .sysClk(sysClk), .reqRate(reqRate),
    .dblIn(dblIn), .busy(busy), .done(done), .preCode(preCode), .sclCode(sclCode),
    .dblRate(dblRate), .rangeErr(rangeErr)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint preOf(input int c);
    case (c) 0: return 2; 1: return 3; 2: return 5; default: return 7; endcase
  endfunction

  function automatic longint sclOf(input int c);
    if (c < 4) return 2 * (c + 1);
    return longint'(1) << c;
  endfunction

  function automatic void refCalc(input longint s, input longint r, input bit dI,
                                  output bit rej, output int bp, output int bs, output bit dbl);
    longint best, c, e;
    rej = (r > s / 2) || (r < s / 229376);
    dbl = dI || (r > s / 4);
    best = 64'h7FFFFFFF;
    bp = 0;
    bs = 0;
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 16; j++) begin
        c = ((s / preOf(i)) / sclOf(j)) * (dbl ? 2 : 1);
        e = (c > r) ? c - r : r - c;
        if (e < best) begin
          best = e; bp = i; bs = j;
        end
      end
  endfunction

  task automatic runOne(input longint s, input longint r, input bit dI, input bit poke);
    bit rej, dbl;
    int bp, bs, n;
    refCalc(s, r, dI, rej, bp, bs, dbl);
    @(negedge clk);
    sysClk = W'(s); reqRate = W'(r); dblIn = dI; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R1 busy after start", busy, 1);
    n = 0;
    while (n < 5000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      start = (poke && n == 5);
      if (done) break;
    end
    start = 1'b0;
    check(n == (rej ? 1 : LAT_OK), "R7 latency", n, rej ? 1 : LAT_OK);
    check(busy === 1'b0, "R1 busy low at done", busy, 0);
    check(rangeErr === rej, "R3 range flag", rangeErr, rej);
    if (!rej) begin
      mPre = bp; mScl = bs; mDbl = dbl;
    end
    check(preCode == 2'(mPre), rej ? "R3 pre held" : "R6 prescale code", preCode, mPre);
    check(sclCode == 4'(mScl), rej ? "R3 scl held" : "R5 scale code", sclCode, mScl);
    check(dblRate === mDbl, rej ? "R3 dbl held" : "R4 double rate", dblRate, mDbl);
    @(negedge clk);
    check(done === 1'b0, "R1 done single cycle", done, 0);
    if (poke) check(busy === 1'b0, "R2 busy start ignored", busy, 0);
  endtask

  initial begin
    longint s, r;
    int sh;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R9 reset busy/done", {busy, done}, 0);
    check(preCode == 0 && sclCode == 0, "R9 reset codes", {preCode, sclCode}, 0);
    check(dblRate === 1'b0 && rangeErr === 1'b0, "R9 reset flags", {dblRate, rangeErr}, 0);
    rstN = 1'b1;
    // R6 tie: 150000 and 200000 are equally far from 175000, earlier pair wins
    runOne(1_200_000, 175_000, 1'b0, 1'b0);
    // R3 upper bound accepted, R4 fast request doubles
    runOne(100_000_000, 50_000_000, 1'b0, 1'b0);
    runOne(100_000_000, 50_000_001, 1'b0, 1'b0);
    // R3 lower bound
    runOne(100_000_000, 435, 1'b0, 1'b0);
    runOne(100_000_000, 434, 1'b0, 1'b0);
    // R4 threshold at a quarter of the clock
    runOne(100_000_000, 25_000_000, 1'b0, 1'b0);
    runOne(100_000_000, 25_000_001, 1'b0, 1'b0);
    // R4 already-doubled input keeps doubling
    runOne(80_000_000, 1_000_000, 1'b1, 1'b0);
    // R2 start pulse during a search
    runOne(66_000_000, 3_300_000, 1'b0, 1'b1);
    for (int k = 0; k < 20; k++) begin
      s = longint'($urandom_range(500_000_000, 2_000_000));
      sh = int'($urandom_range(19, 1));
      r = (s >> sh) + longint'($urandom_range(32'(s >> (sh + 1)), 0));
      runOne(s, r, ($urandom_range(3, 0) == 0), (k % 7) == 3);
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #800000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule